// File: doc/BRIEF.md
# Dual-Source Timer Count-Enable Prescaler

This block produces a count-enable pulse for each of eight timer channels. Two oscillators feed it. The fast one is the system clock itself. The slow 32 kHz one arrives as a single-cycle tick that has already been synchronized into the system clock domain. Each source drives one shared free-running 8-bit divider chain. A channel's 4-bit select code picks one source and one power-of-two tap of that chain, or turns the channel off.

Software programs the codes over a byte-wide register port. Each channel's code sits at its own address, and the address equals the channel number. Every output is a registered one-cycle enable pulse, not a derived clock. A timer counter downstream advances only on cycles where its enable is high.

Top module: `tmr_clk_sel`

## Requirements
- R1: After reset, every select code is 0x0, every `cnt_en` bit is low, and every address reads back 0x00.
- R2: A channel with code 0x0 never raises its `cnt_en` bit.
- R3: Codes 0xF, 0xE, 0xD, 0xC, 0xB, 0xA, 0x9 and 0x8 give a one-cycle pulse once every 1, 2, 4, 8, 16, 32, 64 and 256 system clock cycles respectively. Code 0xF holds the enable high on every cycle.
- R4: Codes 0x7, 0x6, 0x5, 0x4, 0x3, 0x2 and 0x1 give one pulse for every 1, 2, 4, 16, 32, 64 and 256 slow ticks respectively. A pulse appears only in the cycle right after a slow tick.
- R5: The channels are independent. Each `cnt_en[c]` follows only the code of channel c.
- R6: A write stores `reg_wdata[3:0]` into the code of the channel at `reg_addr`. The new code governs `cnt_en` from the cycle after the write edge. The write cycle itself still reflects the old code, so no extra or split pulse appears.
- R7: `reg_rdata` is registered. One cycle after an address is presented, it returns that channel's code in bits [3:0], and bits [7:4] read as zero. A write to the same address in that cycle returns the old code.
- R8: The two divider chains run freely and are never reset by register writes. A channel joining an active source therefore lines up with pulses already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which is also the fast oscillator |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per slow-oscillator period, already synchronized |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Channel address |
| reg_wdata | input | 8 | Write data; only bits [3:0] are kept |
| reg_rdata | output | 8 | Registered read data |
| cnt_en | output | 8 | Per-channel count-enable pulses |

## Verification
Two events can fall in the same cycle: a register write to a channel, and that channel emitting a pulse under its old code. A second pair is a read and a write to the same address. The bench switches a channel between 0x0 and 0xF, the code that pulses on every cycle. It then checks the enable on the write cycle and on the cycle after, so a pulse that is doubled, dropped or late shows up at once. It also writes and reads one address together and expects the old code first, then the new one. Rate checks count pulses over a window that spans whole divider periods, so the result does not depend on phase.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int CODE_W = 4;
  localparam int TAP_W  = 4;

  typedef struct packed {
    logic             on;
    logic             slow;
    logic [TAP_W-1:0] tap;
  } sel_t;

  function automatic sel_t decode_code(input logic [CODE_W-1:0] code);
    sel_t s;
    logic [2:0] lo;
    lo     = code[2:0];
    s.on   = (code != '0);
    s.slow = ~code[3];
    if (code[3]) begin
      s.tap = (lo == 3'd0) ? TAP_W'(8) : TAP_W'(3'd7 - lo);
    end else if (lo >= 3'd5) begin
      s.tap = TAP_W'(3'd7 - lo);
    end else if (lo == 3'd1) begin
      s.tap = TAP_W'(8);
    end else begin
      s.tap = TAP_W'(4'd8 - {1'b0, lo});
    end
    return s;
  endfunction
endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  output logic [DIV_W:0] taps
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end

  assign taps[0] = adv;
  for (genvar k = 1; k <= DIV_W; k++) begin : g_tap
    assign taps[k] = adv & (&cnt_q[k-1:0]);
  end

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> cnt_q == $past(cnt_q));
  p_top_tap_wraps_r3: assert property (@(posedge clk) disable iff (rst)
    taps[DIV_W] |=> cnt_q == '0);
endmodule

// File: rtl/tcs_regfile.sv
module tcs_regfile #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [NUM_CH-1:0][CODE_W-1:0] codes
);
  logic [NUM_CH-1:0][CODE_W-1:0] codes_q;
  wire in_range = (32'(addr) < NUM_CH);

  always_ff @(posedge clk) begin
    if (rst) begin
      codes_q <= '0;
      rdata   <= '0;
    end else begin
      if (we && in_range) codes_q[addr] <= wdata[CODE_W-1:0];
      rdata <= in_range ? DATA_W'(codes_q[addr]) : '0;
    end
  end

  assign codes = codes_q;

  p_rdata_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:CODE_W] == '0);
  p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
    (we && in_range) |=> codes_q[$past(addr)] == $past(wdata[CODE_W-1:0]));
endmodule

// File: rtl/tcs_chan_mux.sv
module tcs_chan_mux
  import tcs_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic [DIV_W:0]    fast_taps,
  input  logic [DIV_W:0]    slow_taps,
  output logic              en_q
);
  sel_t sel;
  logic pick;

  always_comb begin
    sel  = decode_code(code);
    pick = 1'b0;
    if (sel.on) pick = sel.slow ? slow_taps[sel.tap] : fast_taps[sel.tap];
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= pick;
  end

  p_off_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (code == '0) |=> !en_q);
  p_fast_full_rate_r3: assert property (@(posedge clk) disable iff (rst)
    (code == '1) |=> en_q);
  p_slow_needs_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (!code[CODE_W-1] && !slow_taps[0]) |=> !en_q);
endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tcs_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] cnt_en
);
  logic [DIV_W:0]                fast_taps;
  logic [DIV_W:0]                slow_taps;
  logic [NUM_CH-1:0][CODE_W-1:0] codes;

  tcs_prescaler #(.DIV_W(DIV_W)) u_fast (
    .clk(clk), .rst(rst), .adv(1'b1), .taps(fast_taps));

  tcs_prescaler #(.DIV_W(DIV_W)) u_slow (
    .clk(clk), .rst(rst), .adv(slow_tick), .taps(slow_taps));

  tcs_regfile #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .DATA_W(DATA_W),
                .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .codes(codes));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tcs_chan_mux #(.DIV_W(DIV_W)) u_mux (
      .clk(clk), .rst(rst), .code(codes[c]),
      .fast_taps(fast_taps), .slow_taps(slow_taps), .en_q(cnt_en[c]));
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (cnt_en == '0 && reg_rdata == '0));
endmodule

// File: tb/tmr_clk_sel_test.sv
`timescale 1ns/1ps
module tmr_clk_sel_test;
  localparam int NCH  = 8;
  localparam int WIN  = 1024;
  localparam int TPER = 4;

  localparam logic [3:0] CODE_T [16] = '{4'hF, 4'hE, 4'hD, 4'hC, 4'hB, 4'hA, 4'h9, 4'h8,
                                         4'h7, 4'h6, 4'h5, 4'h4, 4'h3, 4'h2, 4'h1, 4'h0};
  localparam int EXP_T [16] = '{1024, 512, 256, 128, 64, 32, 16, 4,
                                256, 128, 64, 16, 8, 4, 1, 0};

  logic clk = 0, rst = 1, slow_tick = 0, reg_we = 0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [NCH-1:0] cnt_en;
  int tests = 0, fails = 0;
  int pcnt [NCH];

  tmr_clk_sel uut (.clk(clk), .rst(rst), .slow_tick(slow_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_en(cnt_en));

  always #5 clk = ~clk;

  initial begin : tick_gen
    int t = 0;
    forever begin
      @(negedge clk);
      t++;
      slow_tick <= (t % TPER == 0);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 3'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin : watchdog
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 cnt_en", int'(cnt_en), 0);
    for (int a = 0; a < NCH; a++) begin
      rd(a, v);
      check("R1 readback", v, 0);
    end
    check("R2 code0 silent", int'(cnt_en), 0);

    // Table walk: channel c gets entry (i+c)%16; R3 R4 R5 R8
    for (int i = 0; i < 16; i++) begin
      for (int c = 0; c < NCH; c++) wr(c, CODE_T[(i + c) % 16]);
      repeat (2) @(negedge clk);
      for (int c = 0; c < NCH; c++) pcnt[c] = 0;
      for (int n = 0; n < WIN; n++) begin
        @(negedge clk);
        for (int c = 0; c < NCH; c++) if (cnt_en[c]) pcnt[c]++;
      end
      for (int c = 0; c < NCH; c++) begin
        int e;
        e = (i + c) % 16;
        check(CODE_T[e] == 4'h0 ? "R2 off" : (CODE_T[e][3] ? "R3 fast" : "R4 slow"),
              pcnt[c], EXP_T[e]);
      end
    end

    // R7 readback upper nibble zero
    wr(2, 8'hFA);
    rd(2, v);
    check("R7 low nibble only", v, 8'h0A);

    // R7 same-cycle read and write returns old code
    wr(3, 5);
    rd(3, v);
    @(negedge clk);
    reg_we = 1; reg_addr = 3'd3; reg_wdata = 8'h0C;
    @(negedge clk);
    reg_we = 0;
    check("R7 old on collision", int'(reg_rdata), 5);
    @(negedge clk);
    check("R7 new after", int'(reg_rdata), 12);

    // R6 handover: off -> full rate -> off
    for (int c = 0; c < NCH; c++) wr(c, 0);
    repeat (3) @(negedge clk);
    wr(0, 8'h0F);
    check("R6 write cycle old code", int'(cnt_en[0]), 0);
    @(negedge clk);
    check("R6 new code next cycle", int'(cnt_en[0]), 1);
    check("R5 neighbours quiet", int'(cnt_en[NCH-1:1]), 0);
    wr(0, 0);
    check("R6 last pulse on write cycle", int'(cnt_en[0]), 1);
    @(negedge clk);
    check("R6 stopped next cycle", int'(cnt_en[0]), 0);

    // R1 reset mid-run clears codes
    wr(5, 8'h0F);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 cnt_en after reset", int'(cnt_en), 0);
    rd(5, v);
    check("R1 code cleared", v, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule